// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the divider settings of a frequency synthesizer: a 9-bit feedback divide value (M), a 2-bit post-divider code (N) and a 3-bit test-select code (T). Two paths can load the settings. The parallel path takes M and N from pins and is controlled by a level/edge strobe. The serial path shifts a 14-bit frame in on a serial clock and then commits it with its own load strobe.

All strobe and data inputs are sampled on the system clock `clk_i`. Edges on the strobes are found by comparing each sampled value with the value from the previous cycle. Every output comes from a register, so an input change that is sampled at a clock edge shows on the outputs right after that same edge.

The active settings drive the synthesizer's dividers. The most significant bit of the shift register is brought out for a test multiplexer further downstream.

Top module: `synth_div_cfg`

## Requirements
- R1: While `rst_ni` is low, `m_o`, `n_o` and `t_o` are 0, and the shift register is cleared, so `sdo_o` is 0.
- R2: A clock edge that samples `p_load_i` low copies `m_i` and `n_i` into `m_o` and `n_o`. The parallel path is transparent in this state.
- R3: At the first clock edge that samples `p_load_i` high after it was low, `m_i` and `n_i` are captured into `m_o` and `n_o`.
- R4: While `p_load_i` stays high, changes on `m_i` and `n_i` have no effect on `m_o` and `n_o`.
- R5: While `p_load_i` is high, a rising edge of `s_clk_i` shifts `s_data_i` into bit 0 of the 14-bit shift register. `sdo_o` is always bit 13.
- R6: The frame is sent T field first, then N, then M, and each field goes most significant bit first. After 14 shifts, bits [13:11] hold T, bits [10:9] hold N and bits [8:0] hold M.
- R7: While `p_load_i` was high in both the current and the previous sample, a falling edge of `s_load_i` copies the shift register into `t_o`, `n_o` and `m_o`.
- R8: While `p_load_i` is low, `s_clk_i` edges do not shift and `s_load_i` falls do not commit.
- R9: While `p_load_i` is sampled low, `t_o` is forced to 000.
- R10: `t_o` changes only through a serial commit, or through reset or R9. A parallel capture leaves it unchanged, and the capture takes precedence over a `s_load_i` fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples all other inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p_load_i | input | 1 | Parallel strobe: low is transparent, a rise captures, high enables the serial path |
| m_i | input | 9 | Parallel M value |
| n_i | input | 2 | Parallel N code |
| s_clk_i | input | 1 | Serial shift clock, acts on its rising edge |
| s_data_i | input | 1 | Serial data |
| s_load_i | input | 1 | Serial commit strobe, acts on its falling edge |
| m_o | output | 9 | Active M |
| n_o | output | 2 | Active N |
| t_o | output | 3 | Active test-select code |
| sdo_o | output | 1 | Shift register MSB |

## Verification
The hardest case to reach is serial activity while `p_load_i` is low. Shifts and commits made in that state must leave no trace. The only way to see that from the ports is to raise `p_load_i` afterwards, commit, and compare the result with a frame loaded beforehand. The stimulus loads a known frame, then sends random serial clock and load pulses with the parallel strobe low, and then commits. It also drives a parallel rise and a serial-load fall in the same cycle to check which one wins.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int FRAME_W = T_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } div_cfg_t;
endpackage

// File: rtl/synth_cfg_edge.sv
module synth_cfg_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               d_i,
  output logic [FRAME_W-1:0] q_o
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= {sh_q[FRAME_W-2:0], d_i};
  end

  assign q_o = sh_q;
endmodule

// File: rtl/synth_cfg_active.sv
module synth_cfg_active
  import synth_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           p_load_i,
  input  logic           p_rise_i,
  input  logic           commit_i,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  input  div_cfg_t       frame_i,
  output div_cfg_t       cfg_o
);
  div_cfg_t cfg_q;

  // priority: transparent low, then parallel capture, then serial commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (!p_load_i) begin
      cfg_q.m <= m_i;
      cfg_q.n <= n_i;
      cfg_q.t <= '0;
    end else if (p_rise_i) begin
      cfg_q.m <= m_i;
      cfg_q.n <= n_i;
    end else if (commit_i) begin
      cfg_q <= frame_i;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg
  import synth_cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           p_load_i,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  input  logic           s_clk_i,
  input  logic           s_data_i,
  input  logic           s_load_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] t_o,
  output logic           sdo_o
);
  logic               p_rise, sclk_rise, sload_fall;
  logic [FRAME_W-1:0] frame;
  div_cfg_t           cfg;

  synth_cfg_edge #(.RISING(1'b1)) i_p_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(p_load_i), .edge_o(p_rise));
  synth_cfg_edge #(.RISING(1'b1)) i_sclk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(s_clk_i), .edge_o(sclk_rise));
  synth_cfg_edge #(.RISING(1'b0)) i_sload_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(s_load_i), .edge_o(sload_fall));

  synth_cfg_shift i_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (sclk_rise & p_load_i),
    .d_i   (s_data_i),
    .q_o   (frame)
  );

  synth_cfg_active i_active (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .p_load_i(p_load_i),
    .p_rise_i(p_rise),
    .commit_i(sload_fall),
    .m_i     (m_i),
    .n_i     (n_i),
    .frame_i (div_cfg_t'(frame)),
    .cfg_o   (cfg)
  );

  assign m_o   = cfg.m;
  assign n_o   = cfg.n;
  assign t_o   = cfg.t;
  assign sdo_o = frame[FRAME_W-1];
endmodule

// File: rtl/synth_div_cfg_chk.sv
module synth_div_cfg_chk
  import synth_cfg_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           p_load_i,
  input logic [M_W-1:0] m_i,
  input logic [N_W-1:0] n_i,
  input logic           s_clk_i,
  input logic           s_data_i,
  input logic           s_load_i,
  input logic [M_W-1:0] m_o,
  input logic [N_W-1:0] n_o,
  input logic [T_W-1:0] t_o,
  input logic           sdo_o
);
  logic pl_d, sc_d, sl_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pl_d <= 1'b0; sc_d <= 1'b0; sl_d <= 1'b0;
    end else begin
      pl_d <= p_load_i; sc_d <= s_clk_i; sl_d <= s_load_i;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (m_o == '0 && n_o == '0 && t_o == '0 && !sdo_o));

  a_r2_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_load_i |=> (m_o == $past(m_i) && n_o == $past(n_i)));

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_load_i && !pl_d) |=> (m_o == $past(m_i) && n_o == $past(n_i) && $stable(t_o)));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_load_i && pl_d && !(sl_d && !s_load_i)) |=>
      ($stable(m_o) && $stable(n_o) && $stable(t_o)));

  a_r8_no_shift_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_load_i |=> $stable(sdo_o));

  a_r5_shift_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_clk_i && !sc_d) |=> $stable(sdo_o));

  a_r9_t_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_load_i |=> (t_o == '0));
endmodule

bind synth_div_cfg synth_div_cfg_chk i_chk (.*);

// File: tb/test_synth_div_cfg.sv
module test_synth_div_cfg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       p_load_i = 1'b0;
  logic [8:0] m_i = '0;
  logic [1:0] n_i = '0;
  logic       s_clk_i = 1'b0, s_data_i = 1'b0, s_load_i = 1'b0;
  logic [8:0] m_o;
  logic [1:0] n_o;
  logic [2:0] t_o;
  logic       sdo_o;

  int total = 0, bad = 0;
  int unsigned seed = 32'h5eed_1234;

  // reference state
  logic        pv_p = 0, pv_sc = 0, pv_sl = 0;
  logic [13:0] e_sh = '0;
  logic [8:0]  e_m = '0;
  logic [1:0]  e_n = '0;
  logic [2:0]  e_t = '0;

  always #5 clk_i = ~clk_i;

  synth_div_cfg i_synth_div_cfg (.*);

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [13:0] mk_frame(logic [2:0] t, logic [1:0] n, logic [8:0] m);
    return {t, n, m};
  endfunction

  task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_cfg(string req);
    chk(req, {t_o, n_o, m_o}, {e_t, e_n, e_m});
  endtask

  // drive one clock cycle; reference updated from the requirements
  task automatic step(logic p, logic [8:0] m, logic [1:0] n, logic sc, logic sd, logic sl);
    p_load_i = p; m_i = m; n_i = n; s_clk_i = sc; s_data_i = sd; s_load_i = sl;
    @(posedge clk_i);
    if (!p) begin
      e_m = m; e_n = n; e_t = '0;                      // R2, R9
    end else if (!pv_p) begin
      e_m = m; e_n = n;                                // R3, R10
    end else if (pv_sl && !sl) begin
      {e_t, e_n, e_m} = e_sh;                          // R7
    end
    if (p && sc && !pv_sc) e_sh = {e_sh[12:0], sd};    // R5, R8
    pv_p = p; pv_sc = sc; pv_sl = sl;
    @(negedge clk_i);
  endtask

  task automatic send_frame(logic [13:0] f, logic p);
    for (int i = 13; i >= 0; i--) begin
      step(p, m_i, n_i, 1'b1, f[i], 1'b1);
      step(p, m_i, n_i, 1'b0, f[i], 1'b1);
      if (p) chk("R5 sdo", {13'b0, sdo_o}, {13'b0, e_sh[13]});
    end
  endtask

  task automatic commit(logic p);
    step(p, m_i, n_i, 1'b0, 1'b0, 1'b1);
    step(p, m_i, n_i, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 reset cfg", {t_o, n_o, m_o}, 14'h0);
    chk("R1 reset sdo", {13'b0, sdo_o}, 14'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: transparent while low
    step(1'b0, 9'd262, 2'b01, 0, 0, 1);
    chk("R2 transparent", {t_o, n_o, m_o}, mk_frame(3'b0, 2'b01, 9'd262));
    step(1'b0, 9'h1ab, 2'b11, 0, 0, 1);
    chk("R2 follow", {t_o, n_o, m_o}, mk_frame(3'b0, 2'b11, 9'h1ab));

    // R3: capture on rise; R4: pins ignored afterwards
    step(1'b1, 9'h0f0, 2'b10, 0, 0, 1);
    chk("R3 capture", {t_o, n_o, m_o}, mk_frame(3'b0, 2'b10, 9'h0f0));
    step(1'b1, 9'h155, 2'b01, 0, 0, 1);
    step(1'b1, 9'h0aa, 2'b11, 0, 0, 1);
    chk("R4 hold", {t_o, n_o, m_o}, mk_frame(3'b0, 2'b10, 9'h0f0));

    // R6/R7: full frame, fields placed T,N,M msb first
    send_frame(mk_frame(3'b110, 2'b01, 9'h106), 1'b1);
    chk("R6 pre-commit unchanged", {t_o, n_o, m_o}, mk_frame(3'b0, 2'b10, 9'h0f0));
    chk("R6 sdo is T2", {13'b0, sdo_o}, 14'd1);
    commit(1'b1);
    chk("R7 commit", {t_o, n_o, m_o}, mk_frame(3'b110, 2'b01, 9'h106));
    chk("R6 fields", {t_o, n_o, m_o}, 14'b110_01_100000110);

    // R8: serial activity with p_load low leaves no trace
    step(1'b0, 9'h033, 2'b00, 0, 0, 1);
    chk("R9 t forced", {11'b0, t_o}, 14'd0);
    send_frame(14'h2a5a, 1'b0);
    commit(1'b0);
    chk("R8 no commit low", {t_o, n_o, m_o}, mk_frame(3'b0, 2'b00, 9'h033));
    step(1'b1, 9'h033, 2'b00, 0, 0, 1);
    commit(1'b1);
    chk("R8 shift untouched", {t_o, n_o, m_o}, mk_frame(3'b110, 2'b01, 9'h106));

    // R10: parallel rise beats s_load fall in the same cycle; T kept
    step(1'b1, 9'h033, 2'b00, 0, 0, 1);
    step(1'b0, 9'h044, 2'b11, 0, 0, 1);
    send_frame(mk_frame(3'b011, 2'b10, 9'h1ff), 1'b0);
    step(1'b0, 9'h044, 2'b11, 0, 0, 1);
    step(1'b1, 9'h077, 2'b01, 0, 0, 0);
    chk("R10 rise wins", {t_o, n_o, m_o}, mk_frame(3'b0, 2'b01, 9'h077));
    send_frame(mk_frame(3'b101, 2'b11, 9'h001), 1'b1);
    commit(1'b1);
    step(1'b1, 9'h1ee, 2'b00, 0, 0, 1);
    chk("R10 t via serial only", {11'b0, t_o}, 14'd5);

    // random mix checked every cycle against the reference
    for (int k = 0; k < 3000; k++) begin
      logic p, sc, sd, sl;
      p  = ($urandom(seed) % 8) != 0;
      seed = seed + 1;
      sc = $urandom % 2;
      sd = $urandom % 2;
      sl = ($urandom % 4) != 0;
      step(p, 9'($urandom), 2'($urandom), sc, sd, sl);
      chk("R2/R3/R4/R7/R9 random", {t_o, n_o, m_o}, {e_t, e_n, e_m});
      chk("R5/R8 random sdo", {13'b0, sdo_o}, {13'b0, e_sh[13]});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule